// File: doc/BRIEF.md
# GPIO Controller with Polarity-Normalized Interrupts

This block is a memory-mapped general-purpose I/O controller on a small 32-bit register port. Each pin has an output-enable bit and an output data bit, which go to the pad cell as a drive value and a tristate control. Each pin also has a readable input bit, taken through a two-flop synchronizer. The input register shows the synchronized pad value in every output-enable state.

A contiguous window of pins, `NUM_IRQ` wide and starting at pin `IRQ_BASE`, can be moved from plain I/O to interrupt use. Interrupt line n serves pin `IRQ_BASE + n`. Each line has a programmable active level. The block compares the synchronized pin against that level and sends a registered, always active-high request to a parent interrupt controller. Edge capture, masking and end-of-interrupt handling belong to the parent. The even-bit select layout limits the window to pins below 16.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every register reads zero. `pad_oe`, `pad_do`, `irq_out` and `rdata` are all zero.
- R2: The output-enable register (offset 0x29C) and the output data register (offset 0x2A0) hold one bit per pin at bit position = pin number. Bits at or above `NUM_PINS` read zero and ignore writes. `pad_oe` and `pad_do` present these registers, and a 1 in `pad_oe` means the pin is driven.
- R3: The input register (offset 0x2A4) returns the pad values after a two-flop synchronizer, whatever the output-enable setting. A read issued one cycle after a pad change still returns the old value.
- R4: In the select register (offset 0x294), bit 2×p enables interrupt use of pin p. Only pins `IRQ_BASE`..`IRQ_BASE+NUM_IRQ-1` store this bit. All other bits read zero and ignore writes.
- R5: In the level register (offset 0x290), bit n belongs to interrupt line n, not to a pin number. A 1 there means the pin is active high and a 0 means it is active low. Bits at or above `NUM_IRQ` read zero and ignore writes.
- R6: `irq_out[n]` is 1 exactly when the select bit of pin `IRQ_BASE+n` is set and the synchronized pin equals level bit n. The output is registered, so it is 1 for both a high-active pin at 1 and a low-active pin at 0.
- R7: While the select bit of a line's pin is clear, that line stays 0 for every pin value and every level setting.
- R8: A read returns its data in `rdata` on the clock edge after `rd_en`, and `rdata` holds while `rd_en` is low. Any offset other than the five listed above reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, takes effect on this clock edge |
| rd_en | input | 1 | Read strobe, data appears one cycle later |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| pad_in | input | NUM_PINS | Raw pad input values |
| pad_do | output | NUM_PINS | Pad drive values |
| pad_oe | output | NUM_PINS | Pad drive enable, 1 = driven, 0 = tristate |
| irq_out | output | NUM_IRQ | Active-high interrupt requests to the parent controller |

## Verification
The bench drives every interrupt line with both level settings against both pin values. A design that forgot the inversion for low-active pins, or that indexed the level register by pin number, would raise the wrong lines in that table. It also toggles pads and levels while all select bits are clear, to catch a line that ignores its select bit. The select register is written with all ones and then with only odd bits; this exposes a design that stores select bits at pin positions rather than at 2×pin, or that keeps bits for pins that cannot interrupt. A read one cycle after a pad change must still return the old value, and a design that drops a synchronizer stage would fail that check.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_LEVEL  = 12'h290;
  localparam logic [ADDR_W-1:0] OFS_SELECT = 12'h294;
  localparam logic [ADDR_W-1:0] OFS_DRVEN  = 12'h29C;
  localparam logic [ADDR_W-1:0] OFS_DOUT   = 12'h2A0;
  localparam logic [ADDR_W-1:0] OFS_DIN    = 12'h2A4;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_LEVEL,
    RSEL_SELECT,
    RSEL_DRVEN,
    RSEL_DOUT,
    RSEL_DIN
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_LEVEL:  return RSEL_LEVEL;
      OFS_SELECT: return RSEL_SELECT;
      OFS_DRVEN:  return RSEL_DRVEN;
      OFS_DOUT:   return RSEL_DOUT;
      OFS_DIN:    return RSEL_DIN;
      default:    return RSEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int NUM_IRQ  = 6,
  parameter int IRQ_BASE = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] pin_sync,
  output logic [NUM_PINS-1:0] drv_en,
  output logic [NUM_PINS-1:0] drv_val,
  output logic [NUM_IRQ-1:0]  lvl_hi,
  output logic [NUM_IRQ-1:0]  irq_sel
);
  localparam int SEL_TOP = 2 * (IRQ_BASE + NUM_IRQ - 1);

  reg_sel_e            rsel;
  logic [NUM_PINS-1:0] en_q,  en_d;
  logic [NUM_PINS-1:0] val_q, val_d;
  logic [NUM_IRQ-1:0]  lvl_q, lvl_d;
  logic [NUM_IRQ-1:0]  sel_q, sel_d;
  logic [DATA_W-1:0]   rd_q,  rd_d;
  logic                unused_wdata;

  assign rsel         = decode_ofs(addr);
  assign unused_wdata = ^wdata;

  // next-state for the writable registers
  always_comb begin
    en_d  = en_q;
    val_d = val_q;
    lvl_d = lvl_q;
    sel_d = sel_q;
    case (rsel)
      RSEL_DRVEN: en_d  = wdata[NUM_PINS-1:0];
      RSEL_DOUT:  val_d = wdata[NUM_PINS-1:0];
      RSEL_LEVEL: lvl_d = wdata[NUM_IRQ-1:0];
      RSEL_SELECT: begin
        for (int n = 0; n < NUM_IRQ; n++) begin
          sel_d[n] = wdata[2*(IRQ_BASE+n)];
        end
      end
      default: ;
    endcase
  end

  // read data mux, zero for unmapped offsets
  always_comb begin
    rd_d = '0;
    case (rsel)
      RSEL_DRVEN: rd_d[NUM_PINS-1:0] = en_q;
      RSEL_DOUT:  rd_d[NUM_PINS-1:0] = val_q;
      RSEL_DIN:   rd_d[NUM_PINS-1:0] = pin_sync;
      RSEL_LEVEL: rd_d[NUM_IRQ-1:0]  = lvl_q;
      RSEL_SELECT: begin
        for (int n = 0; n < NUM_IRQ; n++) begin
          rd_d[2*(IRQ_BASE+n)] = sel_q[n];
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      val_q <= '0;
      lvl_q <= '0;
      sel_q <= '0;
      rd_q  <= '0;
    end else begin
      if (wr_en) begin
        en_q  <= en_d;
        val_q <= val_d;
        lvl_q <= lvl_d;
        sel_q <= sel_d;
      end
      if (rd_en) begin
        rd_q <= rd_d;
      end
    end
  end

  generate
    if (SEL_TOP >= DATA_W) begin : g_bad_window
      initial $display("gpio_regfile: interrupt window exceeds select register");
    end
  endgenerate

  assign rdata   = rd_q;
  assign drv_en  = en_q;
  assign drv_val = val_q;
  assign lvl_hi  = lvl_q;
  assign irq_sel = sel_q;
endmodule

// File: rtl/gpio_irq_map.sv
module gpio_irq_map #(
  parameter int NUM_IRQ = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_IRQ-1:0] sel,
  input  logic [NUM_IRQ-1:0] lvl_hi,
  input  logic [NUM_IRQ-1:0] pin,
  output logic [NUM_IRQ-1:0] irq
);
  logic [NUM_IRQ-1:0] irq_d;
  logic [NUM_IRQ-1:0] irq_q;

  generate
    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_line
      // active when pin matches programmed level; output always active high
      assign irq_d[n] = sel[n] & ~(pin[n] ^ lvl_hi[n]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= '0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq = irq_q;
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int NUM_IRQ  = 6,
  parameter int IRQ_BASE = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_do,
  output logic [NUM_PINS-1:0] pad_oe,
  output logic [NUM_IRQ-1:0]  irq_out
);
  logic                rst_sn;
  logic [NUM_PINS-1:0] pin_sync;
  logic [NUM_IRQ-1:0]  lvl_hi;
  logic [NUM_IRQ-1:0]  irq_sel;
  logic [NUM_IRQ-1:0]  pin_irq;

  gpio_rst_sync u_rst (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_sn)
  );

  gpio_in_sync #(.WIDTH(NUM_PINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_sn),
    .d     (pad_in),
    .q     (pin_sync)
  );

  gpio_regfile #(
    .NUM_PINS (NUM_PINS),
    .NUM_IRQ  (NUM_IRQ),
    .IRQ_BASE (IRQ_BASE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .rdata    (rdata),
    .pin_sync (pin_sync),
    .drv_en   (pad_oe),
    .drv_val  (pad_do),
    .lvl_hi   (lvl_hi),
    .irq_sel  (irq_sel)
  );

  assign pin_irq = pin_sync[IRQ_BASE +: NUM_IRQ];

  gpio_irq_map #(.NUM_IRQ(NUM_IRQ)) u_irq (
    .clk    (clk),
    .rst_n  (rst_sn),
    .sel    (irq_sel),
    .lvl_hi (lvl_hi),
    .pin    (pin_irq),
    .irq    (irq_out)
  );
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int NUM_PINS = 22,
  parameter int NUM_IRQ  = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [NUM_PINS-1:0] wdata_lo,
  input logic [DATA_W-1:0]   rdata,
  input logic [NUM_PINS-1:0] pad_oe,
  input logic [NUM_IRQ-1:0]  irq_out,
  input logic [NUM_IRQ-1:0]  sel,
  input logic [NUM_IRQ-1:0]  lvl,
  input logic [NUM_IRQ-1:0]  pin_irq
);
  a_r7_quiet_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_out & ~$past(sel)) == '0);

  a_r6_line_tracks_level: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(sel & ~(pin_irq ^ lvl)));

  a_r2_drive_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_DRVEN) |=> pad_oe == $past(wdata_lo));

  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && decode_ofs(addr) == RSEL_NONE) |=> rdata == '0);

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .NUM_IRQ  (NUM_IRQ)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_sn),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .addr     (addr),
  .wdata_lo (wdata[NUM_PINS-1:0]),
  .rdata    (rdata),
  .pad_oe   (pad_oe),
  .irq_out  (irq_out),
  .sel      (irq_sel),
  .lvl      (lvl_hi),
  .pin_irq  (pin_irq)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 22;
  localparam int NI = 6;
  localparam int IB = 8;
  localparam int NVEC = 10;

  // each row: {select, level, pin window, expected irq}
  localparam logic [23:0] VEC [NVEC] = '{
    {6'h3F, 6'h3F, 6'h3F, 6'h3F},
    {6'h3F, 6'h00, 6'h00, 6'h3F},
    {6'h3F, 6'h3F, 6'h00, 6'h00},
    {6'h3F, 6'h00, 6'h3F, 6'h00},
    {6'h00, 6'h3F, 6'h3F, 6'h00},
    {6'h00, 6'h00, 6'h00, 6'h00},
    {6'h15, 6'h0F, 6'h35, 6'h05},
    {6'h3C, 6'h33, 6'h0F, 6'h00},
    {6'h3F, 6'h2A, 6'h2A, 6'h3F},
    {6'h3F, 6'h15, 6'h2A, 6'h00}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en, rd_en;
  logic [11:0]   addr;
  logic [31:0]   wdata, rdata;
  logic [NP-1:0] pad_in, pad_do, pad_oe;
  logic [NI-1:0] irq_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  gpio_irq_ctrl dut (
    .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .rd_en (rd_en),
    .addr (addr), .wdata (wdata), .rdata (rdata), .pad_in (pad_in),
    .pad_do (pad_do), .pad_oe (pad_oe), .irq_out (irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] sel_word(input logic [5:0] s);
    logic [31:0] w = '0;
    for (int n = 0; n < NI; n++) w[2*(IB+n)] = s[n];
    return w;
  endfunction

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    addr = '0; wdata = '0; pad_in = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check("R1 pad_oe", {10'd0, pad_oe}, 32'h0);
    check("R1 pad_do", {10'd0, pad_do}, 32'h0);
    check("R1 irq_out", {26'd0, irq_out}, 32'h0);
    rd(12'h290, v); check("R1 level", v, 32'h0);
    rd(12'h294, v); check("R1 select", v, 32'h0);
    rd(12'h29C, v); check("R1 drive enable", v, 32'h0);
    rd(12'h2A0, v); check("R1 output data", v, 32'h0);

    // R2 drive registers, bits beyond the pin count ignored
    wr(12'h29C, 32'hFFFF_FFFF);
    rd(12'h29C, v); check("R2 drive enable readback", v, 32'h003F_FFFF);
    check("R2 pad_oe", {10'd0, pad_oe}, 32'h003F_FFFF);
    wr(12'h2A0, 32'h1234_5678);
    rd(12'h2A0, v); check("R2 output readback", v, 32'h0034_5678);
    check("R2 pad_do", {10'd0, pad_do}, 32'h0034_5678);

    // R3 input path, independent of drive enable, two-stage latency
    pad_in = 22'h2A_AAAA;
    idle(4);
    rd(12'h2A4, v); check("R3 input with drive on", v, 32'h002A_AAAA);
    wr(12'h29C, 32'h0);
    @(negedge clk);
    pad_in = 22'h15_5555;
    rd(12'h2A4, v); check("R3 old value one cycle after change", v, 32'h002A_AAAA);
    idle(3);
    rd(12'h2A4, v); check("R3 input with drive off", v, 32'h0015_5555);

    // R4 select register layout
    wr(12'h294, 32'hFFFF_FFFF);
    rd(12'h294, v); check("R4 select even bits of irq pins", v, 32'h0555_0000);
    wr(12'h294, 32'hAAAA_AAAA);
    rd(12'h294, v); check("R4 odd bits ignored", v, 32'h0);

    // R5 level register width
    wr(12'h290, 32'hFFFF_FFFF);
    rd(12'h290, v); check("R5 level readback", v, 32'h0000_003F);

    // R8 unmapped and hold
    rd(12'h298, v); check("R8 unmapped 0x298", v, 32'h0);
    rd(12'h000, v); check("R8 unmapped 0x000", v, 32'h0);
    rd(12'h290, v);
    idle(3);
    check("R8 rdata holds while idle", rdata, 32'h0000_003F);

    // R6 / R7 vector table
    for (int i = 0; i < NVEC; i++) begin
      logic [5:0] s, l, p, e;
      {s, l, p, e} = VEC[i];
      wr(12'h294, sel_word(s));
      wr(12'h290, {26'd0, l});
      pad_in = {8'hB3, p, 8'h5A};
      idle(4);
      check((s == 6'h00) ? "R7 table row, select clear" : "R6 table row",
            {26'd0, irq_out}, {26'd0, e});
    end

    // R7 sweep: select clear, pins and levels changing
    wr(12'h294, 32'h0);
    for (int k = 0; k < 16; k++) begin
      wr(12'h290, {26'd0, 6'(k * 13)});
      pad_in = {8'h00, 6'(k * 7), 8'h00};
      idle(3);
      check("R7 no request while unselected", {26'd0, irq_out}, 32'h0);
    end

    // R6 single line, low-active then high-active
    wr(12'h294, sel_word(6'h08));
    wr(12'h290, 32'h0);
    pad_in = '0;
    idle(4);
    check("R6 line3 low-active pin low", {26'd0, irq_out}, 32'h08);
    pad_in = 22'h00_0800;
    idle(4);
    check("R6 line3 low-active pin high", {26'd0, irq_out}, 32'h00);
    wr(12'h290, 32'h08);
    idle(3);
    check("R6 line3 high-active pin high", {26'd0, irq_out}, 32'h08);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule